// File: doc/BRIEF.md
# Serial Peripheral Master Receiver

This block is one receive channel of a serial peripheral master. It drives the serial clock and shifts in one word per frame from the slave's data line. Before a transfer, configuration inputs choose a frame of 7 or 8 bits, the bit order, the clock's resting level, whether the first bit is captured half a clock period before the clock starts to move, and a two-stage clock divider. The same inputs also choose between single-transfer and back-to-back operation, and this choice sets where the interrupt fires.

A one-cycle start strobe begins a frame. Each finished word is placed in a one-entry receive buffer. The host sees the word through a valid flag and takes it with a read strobe. If a new word lands while the previous one is still unread, a sticky overrun flag is raised. The host clears that flag with a one-cycle clear strobe. In continuous mode, a start strobe given during a frame queues the next frame, and that frame follows with no idle gap.

Top module: `spi_master_rx`

## Requirements
- R1: A frame holds 8 bits, or 7 bits when `cfg_len7` is 1. A 7-bit word is right-aligned in `rx_data`, and `rx_data[7]` reads 0.
- R2: When `cfg_lsb_first` is 0, the first bit captured lands in the word's most significant position. When it is 1, the first bit captured lands in bit 0.
- R3: While no frame runs, `sclk` equals `cfg_cpol`. A frame of N bits toggles `sclk` 2N times, starting from that level, so the clock ends back at its resting level.
- R4: With `cfg_early` at 0, a bit is captured on the 1st, 3rd, ... clock edge, and the frame lasts 2N half periods. With `cfg_early` at 1, the first bit is captured one half period before the first edge, later bits are captured on the even edges, and the frame lasts 2N+1 half periods.
- R5: One half period lasts 2^`cfg_prescale` × (`cfg_div`+1) system clock cycles, with a floor of 2 cycles. A frame keeps `busy` high for (half periods × that length) cycles.
- R6: `ovr_flag` goes to 1 when a word completes while `rx_valid` is 1 and no read happens in that cycle. In that case the buffer keeps the newer word. The flag stays at 1 until a cycle with `ovr_clear` at 1 and no new overrun.
- R7: When `cfg_cont` is 0, `irq` pulses for one cycle at the end of the frame. When it is 1, `irq` pulses for one cycle when a word enters the buffer.
- R8: `busy` rises in the cycle after an accepted start and stays high until the frame's last clock edge. After reset it is 0.
- R9: In single mode, a start strobe during a frame is ignored. In continuous mode, a start strobe during a frame makes the next frame begin right after the current one, and `busy` stays high between them.
- R10: `rx_valid` rises when a word enters the buffer and falls in the cycle after `rx_read` is given while it is 1. After reset it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len7 | input | 1 | 1 selects a 7-bit frame, 0 an 8-bit frame |
| cfg_lsb_first | input | 1 | 1 receives the least significant bit first |
| cfg_cpol | input | 1 | Resting level of the serial clock |
| cfg_early | input | 1 | 1 captures the first bit half a period before the clock moves |
| cfg_prescale | input | 4 | Power-of-two prescaler exponent, 0 to 15 |
| cfg_div | input | 7 | Second divider stage, divides by value+1 |
| cfg_cont | input | 1 | 1 selects continuous mode and the buffer interrupt |
| start | input | 1 | One-cycle request to begin a frame |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock to the slave |
| busy | output | 1 | Frame in progress |
| rx_data | output | 8 | Received word |
| rx_valid | output | 1 | Receive buffer holds an unread word |
| rx_read | input | 1 | Host takes the buffered word |
| ovr_flag | output | 1 | Sticky overrun indication |
| ovr_clear | input | 1 | Clears the overrun flag |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its default widths: an 8-bit maximum frame, a 4-bit prescaler exponent and a 7-bit second divider stage. These widths allow the fastest clock of four system cycles per period, so many frames with different settings fit into a short run, and a prescaler of 8 combined with a divide of 128 shows that both divider stages chain correctly. The two frame lengths, both bit orders, both clock levels, both data phases and both interrupt modes are all exercised. A behavioural model follows the serial clock, the buffer, the overrun flag and the interrupt on every cycle.

// File: rtl/spi_rx_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial master receiver.
// Assumes: mode bits are latched together at frame start.
package spi_rx_pkg;

    typedef struct packed {
        logic len_short;   // frame is one bit shorter than the maximum
        logic lsb_first;   // first captured bit goes to bit 0
        logic cpol;        // resting clock level
        logic early;       // first capture half a period before the clock moves
        logic cont;        // back-to-back frames, buffer interrupt
    } rx_mode_t;

endpackage

// File: rtl/spi_rx_clkdiv.sv
`timescale 1ns/1ps
// Two-stage clock divider: a power-of-two prescaler followed by a divide
// of 1..2^DIV_W. Emits one tick per serial half period while run is high.
// Assumes: sel and div stay stable while run is high; counters restart when run is low.
module spi_rx_clkdiv #(
    parameter int PSEL_W = 4,
    parameter int DIV_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PSEL_W-1:0] sel,
    input  logic [DIV_W-1:0]  div,
    output logic              tick
);
    localparam int PRE_W = (1 << PSEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_max;
    logic [PRE_W:0]   one_sh;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_max;
    logic             pre_done;

    // Terminal counts; a total of 1 is raised to 2 to keep the clock at or below sysclk/4.
    always_comb begin
        one_sh   = (PRE_W+1)'(1) << sel;
        pre_max  = PRE_W'(one_sh - 1'b1);
        div_max  = (sel == '0 && div == '0) ? DIV_W'(1) : div;
        pre_done = (pre_q == pre_max);
        tick     = run && pre_done && (div_q == div_max);
    end

    // Prescaler and second-stage counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (pre_done) begin
            pre_q <= '0;
            div_q <= (div_q == div_max) ? '0 : div_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R5
    min_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/spi_rx_engine.sv
`timescale 1ns/1ps
// Frame sequencer: counts half periods, forms the serial clock, captures
// bits in the chosen order and issues a buffer write and an end strobe.
// Assumes: tick comes from a divider running while busy is high.
module spi_rx_engine
    import spi_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PSEL_W = 4,
    parameter int DIV_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rx_mode_t          mode_in,
    input  logic [PSEL_W-1:0] sel_in,
    input  logic [DIV_W-1:0]  div_in,
    input  logic              start,
    input  logic              miso,
    input  logic              tick,
    output logic              busy,
    output logic              sclk,
    output logic [PSEL_W-1:0] lat_sel,
    output logic [DIV_W-1:0]  lat_div,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_word,
    output logic              end_stb,
    output logic              cont_l
);
    localparam int CNT_W = $clog2(2*DATA_W + 2);

    rx_mode_t          lat_q;
    logic [PSEL_W-1:0] sel_q;
    logic [DIV_W-1:0]  div_q;
    logic              busy_q, ph_q, pend_q;
    logic [CNT_W-1:0]  h_q, h_nx, n_bits, last_h, last_smp;
    logic [DATA_W-1:0] sh_q, sh_nx;
    logic              sample_now, toggle_now, restart, start_ok;

    // Frame geometry, edge decisions and the shifted word.
    always_comb begin
        n_bits     = lat_q.len_short ? CNT_W'(DATA_W-1) : CNT_W'(DATA_W);
        last_smp   = CNT_W'(n_bits << 1) - 1'b1;
        last_h     = CNT_W'(n_bits << 1) + CNT_W'(lat_q.early);
        h_nx       = h_q + 1'b1;
        sample_now = tick && h_nx[0];
        toggle_now = tick && (!lat_q.early || h_nx >= CNT_W'(2));
        sh_nx      = lat_q.lsb_first ? {miso, sh_q[DATA_W-1:1]}
                                     : {sh_q[DATA_W-2:0], miso};
        wr_stb     = sample_now && (h_nx == last_smp);
        wr_word    = (lat_q.lsb_first && lat_q.len_short) ? (sh_nx >> 1) : sh_nx;
        end_stb    = tick && (h_nx == last_h);
        restart    = end_stb && (pend_q || (start && lat_q.cont));
        start_ok   = start && !busy_q;
    end

    // Frame state: launch, half-period stepping, queued restart, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ph_q   <= 1'b0;
            pend_q <= 1'b0;
            h_q    <= '0;
            sh_q   <= '0;
            lat_q  <= '0;
            sel_q  <= '0;
            div_q  <= '0;
        end else if (start_ok || restart) begin
            busy_q <= 1'b1;
            ph_q   <= 1'b0;
            pend_q <= 1'b0;
            h_q    <= '0;
            sh_q   <= '0;
            lat_q  <= mode_in;
            sel_q  <= sel_in;
            div_q  <= div_in;
        end else if (busy_q) begin
            if (start && lat_q.cont) pend_q <= 1'b1;
            if (tick)       h_q    <= h_nx;
            if (toggle_now) ph_q   <= ~ph_q;
            if (sample_now) sh_q   <= sh_nx;
            if (end_stb)    busy_q <= 1'b0;
        end
    end

    assign busy    = busy_q;
    assign sclk    = busy_q ? (lat_q.cpol ^ ph_q) : mode_in.cpol;
    assign lat_sel = sel_q;
    assign lat_div = div_q;
    assign cont_l  = lat_q.cont;

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !end_stb) |=> busy_q);
    // R3
    clock_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_stb |=> !ph_q);
    // R4
    tick_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> busy_q);

endmodule

// File: rtl/spi_rx_buffer.sv
`timescale 1ns/1ps
// One-entry receive buffer with valid/read handshake and sticky overrun.
// Assumes: a write and a read in the same cycle hand over without overrun.
module spi_rx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              ovr
);
    // Buffer contents, occupancy and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            if (wr) data <= wdata;
            valid <= wr || (valid && !rd);
            ovr   <= (wr && valid && !rd) || (ovr && !ovr_clr);
        end
    end

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);
    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && valid && !wr) |=> !valid);

endmodule

// File: rtl/spi_master_rx.sv
`timescale 1ns/1ps
// Top of the serial master receiver: ties the frame sequencer, the clock
// divider and the receive buffer together and registers the interrupt.
// Assumes: configuration inputs change only while busy is low.
module spi_master_rx
    import spi_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PSEL_W = 4,
    parameter int DIV_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_len7,
    input  logic              cfg_lsb_first,
    input  logic              cfg_cpol,
    input  logic              cfg_early,
    input  logic [PSEL_W-1:0] cfg_prescale,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_cont,
    input  logic              start,
    input  logic              miso,
    output logic              sclk,
    output logic              busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_read,
    output logic              ovr_flag,
    input  logic              ovr_clear,
    output logic              irq
);
    rx_mode_t          mode_in;
    logic [PSEL_W-1:0] lat_sel;
    logic [DIV_W-1:0]  lat_div;
    logic              tick, wr_stb, end_stb, cont_l, irq_q;
    logic [DATA_W-1:0] wr_word;

    // Gather the mode bits into one struct.
    always_comb begin
        mode_in.len_short = cfg_len7;
        mode_in.lsb_first = cfg_lsb_first;
        mode_in.cpol      = cfg_cpol;
        mode_in.early     = cfg_early;
        mode_in.cont      = cfg_cont;
    end

    spi_rx_engine #(.DATA_W(DATA_W), .PSEL_W(PSEL_W), .DIV_W(DIV_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .sel_in(cfg_prescale),
        .div_in(cfg_div), .start(start), .miso(miso), .tick(tick),
        .busy(busy), .sclk(sclk), .lat_sel(lat_sel), .lat_div(lat_div),
        .wr_stb(wr_stb), .wr_word(wr_word), .end_stb(end_stb), .cont_l(cont_l)
    );

    spi_rx_clkdiv #(.PSEL_W(PSEL_W), .DIV_W(DIV_W)) u_clkdiv (
        .clk(clk), .rst_n(rst_n), .run(busy), .sel(lat_sel), .div(lat_div),
        .tick(tick)
    );

    spi_rx_buffer #(.DATA_W(DATA_W)) u_buffer (
        .clk(clk), .rst_n(rst_n), .wr(wr_stb), .wdata(wr_word), .rd(rx_read),
        .ovr_clr(ovr_clear), .data(rx_data), .valid(rx_valid), .ovr(ovr_flag)
    );

    // Interrupt pulse: word arrival in continuous mode, frame end otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (wr_stb && cont_l) || (end_stb && !cont_l);
    end

    assign irq = irq_q;

    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

endmodule

// File: tb/test_spi_master_rx.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model compared against the outputs on every clock.
module test_spi_master_rx;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_len7 = 0, cfg_lsb_first = 0, cfg_cpol = 0, cfg_early = 0, cfg_cont = 0;
    logic [3:0] cfg_prescale = 0;
    logic [6:0] cfg_div = 0;
    logic start = 0, miso = 0, rx_read = 0, ovr_clear = 0;
    logic sclk, busy, rx_valid, ovr_flag, irq;
    logic [7:0] rx_data;

    int vecs = 0, fails = 0;
    bit miso_one = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    spi_master_rx i_spi_master_rx (
        .clk(clk), .rst_n(rst_n), .cfg_len7(cfg_len7), .cfg_lsb_first(cfg_lsb_first),
        .cfg_cpol(cfg_cpol), .cfg_early(cfg_early), .cfg_prescale(cfg_prescale),
        .cfg_div(cfg_div), .cfg_cont(cfg_cont), .start(start), .miso(miso),
        .sclk(sclk), .busy(busy), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_read(rx_read), .ovr_flag(ovr_flag), .ovr_clear(ovr_clear), .irq(irq)
    );

    // ---- behavioural model ----
    bit m_busy, m_ph, m_pend, m_valid, m_ovr, m_irq, m_wr, pend_n;
    bit c_cont, c_early, c_lsb, c_cpol;
    int m_cnt, m_h, m_half, m_len, m_last, nb;
    logic [7:0] m_data = 0, m_wdata;
    bit smp [0:15];

    task automatic latch_cfg();
        c_cont  = cfg_cont; c_early = cfg_early; c_lsb = cfg_lsb_first; c_cpol = cfg_cpol;
        m_len   = cfg_len7 ? 7 : 8;
        m_half  = (1 << cfg_prescale) * (int'(cfg_div) + 1);
        if (m_half < 2) m_half = 2;
        m_last  = 2 * m_len + (cfg_early ? 1 : 0);
        m_cnt = 0; m_h = 0; m_ph = 0; nb = 0; m_pend = 0; m_busy = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_valid = 0; m_data = 0; m_ovr = 0; m_irq = 0; m_pend = 0;
            m_cnt = 0; m_h = 0; m_ph = 0;
        end else begin
            m_irq = 0; m_wr = 0;
            if (m_busy) begin
                pend_n = m_pend | (start & c_cont);
                m_pend = pend_n;
                m_cnt++;
                if (m_cnt == m_half) begin
                    m_cnt = 0; m_h++;
                    if (!c_early || m_h >= 2) m_ph = ~m_ph;
                    if (m_h % 2 == 1) begin
                        smp[nb] = miso; nb++;
                        if (m_h == 2 * m_len - 1) begin
                            m_wdata = 0;
                            for (int i = 0; i < m_len; i++)
                                if (smp[i]) m_wdata[c_lsb ? i : m_len - 1 - i] = 1'b1;
                            m_wr = 1;
                            if (c_cont) m_irq = 1;
                        end
                    end
                    if (m_h == m_last) begin
                        if (!c_cont) m_irq = 1;
                        if (pend_n) latch_cfg();
                        else m_busy = 0;
                    end
                end
            end else if (start) begin
                latch_cfg();
            end
            if (m_wr && m_valid && !rx_read) m_ovr = 1;
            else if (ovr_clear) m_ovr = 0;
            m_valid = m_wr | (m_valid & ~rx_read);
            if (m_wr) m_data = m_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, then new serial data for the next edge.
    always @(negedge clk) begin
        chk("R3 sclk", 32'(sclk), 32'(m_busy ? (c_cpol ^ m_ph) : cfg_cpol));
        chk("R8 busy", 32'(busy), 32'(m_busy));
        chk("R10 rx_valid", 32'(rx_valid), 32'(m_valid));
        chk("R2 rx_data", 32'(rx_data), 32'(m_data));
        chk("R6 ovr_flag", 32'(ovr_flag), 32'(m_ovr));
        chk("R7 irq", 32'(irq), 32'(m_irq));
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso = miso_one ? 1'b1 : lfsr[0];
    end

    task automatic set_cfg(input bit l7, input bit lsb, input bit pol, input bit erl,
                           input int pre, input int dv, input bit cnt);
        @(negedge clk);
        cfg_len7 = l7; cfg_lsb_first = lsb; cfg_cpol = pol; cfg_early = erl;
        cfg_prescale = 4'(pre); cfg_div = 7'(dv); cfg_cont = cnt;
    endtask

    // Start a frame, optionally pulse start again at count extra_at, return busy length.
    task automatic run_frame(input int extra_at, output int dur);
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        dur = 0;
        while (busy === 1'b1 && dur < 100000) begin
            dur++;
            start = (dur == extra_at);
            @(negedge clk);
        end
        start = 0;
    endtask

    task automatic pulse_read();
        @(negedge clk) rx_read = 1;
        @(negedge clk) rx_read = 0;
    endtask

    task automatic pulse_clear();
        @(negedge clk) ovr_clear = 1;
        @(negedge clk) ovr_clear = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        int d;
        repeat (3) @(negedge clk);
        chk("R8 reset busy", 32'(busy), 0);
        chk("R10 reset rx_valid", 32'(rx_valid), 0);
        rst_n = 1;

        // 8 bits, MSB first, fastest clock: 16 half periods of 2 cycles (R5)
        set_cfg(0, 0, 0, 0, 0, 0, 0);
        run_frame(0, d);
        chk("R5 fastest frame length", 32'(d), 32);
        pulse_read();

        // 7 bits, LSB first, inverted clock, early phase, half period 6: 15 halves (R4)
        set_cfg(1, 1, 1, 1, 1, 2, 0);
        run_frame(0, d);
        chk("R4 early phase frame length", 32'(d), 90);
        pulse_read();

        // 7-bit frame of all ones reads 0x7F (R1)
        miso_one = 1;
        set_cfg(1, 0, 0, 0, 0, 3, 0);
        run_frame(0, d);
        chk("R1 seven-bit word", 32'(rx_data), 32'h7F);
        pulse_read();
        miso_one = 0;

        // Overrun: two unread words, sticky, then cleared (R6)
        set_cfg(0, 1, 0, 1, 0, 1, 0);
        run_frame(0, d);
        run_frame(0, d);
        chk("R6 overrun raised", 32'(ovr_flag), 1);
        run_frame(0, d);
        chk("R6 overrun sticky", 32'(ovr_flag), 1);
        pulse_clear();
        chk("R6 overrun cleared", 32'(ovr_flag), 0);
        pulse_read();

        // Single mode ignores a start during the frame (R9)
        set_cfg(0, 0, 1, 0, 0, 0, 0);
        run_frame(10, d);
        chk("R9 single mode ignores start", 32'(d), 32);
        pulse_read();

        // Continuous mode chains a queued frame with no gap (R9, R7)
        set_cfg(0, 0, 0, 0, 0, 0, 1);
        run_frame(10, d);
        chk("R9 continuous back-to-back", 32'(d), 64);
        pulse_read();

        // Both divider stages: 2^3 * 128 = 1024 cycles per half period (R5)
        set_cfg(0, 1, 1, 0, 3, 127, 0);
        run_frame(0, d);
        chk("R5 slow divider frame length", 32'(d), 16384);
        pulse_read();

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule